// File: doc/BRIEF.md
# LCD Raster Timing Generator with Line-Compare Events

This block produces the raster timing for an LCD panel: horizontal and vertical sync, a data-enable strobe and the pixel coordinates inside the visible window. Everything comes from a set of programmable configuration values for each axis: sync start, sync end, display start, total count and active count. Each line and each frame start with the sync pulse at count 0. The back porch follows, then the active region, then the front porch. The total count closes the line or frame.

A second function raises sticky status events. One is set when a frame enters its vertical sync line. One is set when the first visible line begins. One is set when the current line matches a programmable compare line, and only the low bits of the line counter take part in that compare. Software clears each event by writing a one to it. The current line number is always visible so that blanking and sync state can be derived from it. A two-bit polarity value sets the active level of each sync output.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is low, the pixel and line counters are 0 and all three status bits are 0.
- R2: The pixel counter runs from 0 to h_total-1 and then returns to 0. The line counter advances only in the cycle the pixel counter returns to 0, and it wraps after v_total-1. `cur_line` shows the line counter.
- R3: `hsync` is active while h_sync_start <= pixel < h_sync_end. `vsync` is active while v_sync_start <= line < v_sync_end. Polarity bit 0 sets the active level of `hsync` and bit 1 sets that of `vsync`; a 1 means active high and a 0 means active low.
- R4: `de` is high only when pixel is in [h_disp_start, h_disp_start+h_active) and line is in [v_disp_start, v_disp_start+v_active). During `de`, `pix_x` = pixel-h_disp_start and `pix_y` = line-v_disp_start. Both are 0 when `de` is low.
- R5: Status bit 0 (vertical-sync event) is set at the clock edge that ends cycle 0 of the line numbered v_sync_start.
- R6: Status bit 1 (display-start event) is set at the clock edge that ends cycle 0 of the line numbered v_disp_start.
- R7: Status bit 2 (line-compare event) is set at the clock edge that ends cycle 0 of any line whose low 9 bits equal `cfg_irq_line`. Lines 3 and 515 therefore both match a compare value of 3.
- R8: Status bits stay set until a one is presented on the matching bit of `status_clr`. If a clear and a new event reach the same bit at the same edge, the event wins.
- R9: A total of 0 or 1 on an axis holds that counter at 0. With h_total <= 1 the line counter advances on every cycle.
- R10: `vblank` is high whenever the line is outside [v_disp_start, v_disp_start+v_active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_sync_start | input | 16 | First pixel of horizontal sync |
| cfg_h_sync_end | input | 16 | First pixel after horizontal sync |
| cfg_h_disp_start | input | 16 | First visible pixel |
| cfg_h_active | input | 16 | Visible pixels per line |
| cfg_h_total | input | 16 | Pixels per line |
| cfg_v_sync_start | input | 16 | First line of vertical sync |
| cfg_v_sync_end | input | 16 | First line after vertical sync |
| cfg_v_disp_start | input | 16 | First visible line |
| cfg_v_active | input | 16 | Visible lines per frame |
| cfg_v_total | input | 16 | Lines per frame |
| cfg_irq_line | input | 9 | Line-compare value |
| cfg_sync_pol | input | 2 | Sync active levels (bit 0 horizontal, bit 1 vertical) |
| status_clr | input | 3 | Write-one-to-clear strobe per status bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| vblank | output | 1 | Vertical blanking indicator |
| pix_x | output | 16 | Column inside the visible window |
| pix_y | output | 16 | Row inside the visible window |
| cur_line | output | 16 | Current line counter |
| status | output | 3 | Sticky events: 0 vsync, 1 display start, 2 line compare |

## Verification
A wrong pixel counter shows on `hsync`, `de` and `pix_x` in the same cycle, because those outputs decode the counters with no further register. A line counter that advances on the wrong edge shows on `cur_line` within one line. A wrong status decode or sticky update appears one clock after the offending line start, since status is the only registered output. Random line patterns, clear strobes that collide with events, degenerate totals and a frame taller than 512 lines together expose each of these in the cycle it happens.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int ST_VSYNC = 0;
  localparam int ST_DISP  = 1;
  localparam int ST_LINE  = 2;
  localparam int ST_W     = 3;
  typedef logic [ST_W-1:0] tg_status_t;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] sync_start,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] disp_start,
  input  logic [CW-1:0] active,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] pos,
  output logic          sync_on,
  output logic          disp_on,
  output logic          wrap
);
  localparam int XW = CW + 1;

  // half-open window test, widened so start+length cannot overflow
  function automatic logic in_span(input logic [CW-1:0] c, input logic [CW-1:0] lo,
                                   input logic [XW-1:0] hi_x);
    return ({1'b0, c} >= {1'b0, lo}) && ({1'b0, c} < hi_x);
  endfunction

  // last count of the period; totals of 0 and 1 both pin the counter at 0
  function automatic logic at_last(input logic [CW-1:0] c, input logic [CW-1:0] tot);
    return ({1'b0, c} + XW'(1)) >= {1'b0, tot};
  endfunction

  logic [CW-1:0] cnt_q;
  logic [XW-1:0] disp_end_x;
  logic          last_w;

  assign disp_end_x = {1'b0, disp_start} + {1'b0, active};
  assign last_w     = at_last(cnt_q, total);
  assign wrap       = adv && last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= last_w ? '0 : cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign sync_on = in_span(cnt_q, sync_start, {1'b0, sync_end});
  assign disp_on = in_span(cnt_q, disp_start, disp_end_x);
  assign pos     = disp_on ? cnt_q - disp_start : '0;

  AST_AXIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)); // R2
  AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    disp_on |-> ({1'b0, pos} < {1'b0, active})); // R4
endmodule

// File: rtl/lcd_tg_status.sv
module lcd_tg_status import lcd_tg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  tg_status_t events,
  input  tg_status_t clr,
  output tg_status_t status
);
  tg_status_t status_q;

  // event beats clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | events;
  end

  assign status = status_q;

  AST_VSYNC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    events[ST_VSYNC] |=> status_q[ST_VSYNC]); // R5
  AST_DISP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    events[ST_DISP] |=> status_q[ST_DISP]); // R6
  AST_LINE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    events[ST_LINE] |=> status_q[ST_LINE]); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0) |=> (($past(status_q) & ~$past(clr) & ~status_q) == '0)); // R8
  AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((status_q & $past(clr) & ~$past(events)) == '0)); // R8
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen import lcd_tg_pkg::*; #(
  parameter int CW       = 16,
  parameter int CMP_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       cfg_h_sync_start,
  input  logic [CW-1:0]       cfg_h_sync_end,
  input  logic [CW-1:0]       cfg_h_disp_start,
  input  logic [CW-1:0]       cfg_h_active,
  input  logic [CW-1:0]       cfg_h_total,
  input  logic [CW-1:0]       cfg_v_sync_start,
  input  logic [CW-1:0]       cfg_v_sync_end,
  input  logic [CW-1:0]       cfg_v_disp_start,
  input  logic [CW-1:0]       cfg_v_active,
  input  logic [CW-1:0]       cfg_v_total,
  input  logic [CMP_BITS-1:0] cfg_irq_line,
  input  logic [1:0]          cfg_sync_pol,
  input  logic [ST_W-1:0]     status_clr,
  output logic                hsync,
  output logic                vsync,
  output logic                de,
  output logic                vblank,
  output logic [CW-1:0]       pix_x,
  output logic [CW-1:0]       pix_y,
  output logic [CW-1:0]       cur_line,
  output logic [ST_W-1:0]     status
);
  logic [CW-1:0] h_cnt, v_cnt, h_pos, v_pos;
  logic          h_sync_on, v_sync_on, h_disp_on, v_disp_on;
  logic          h_wrap, v_wrap;
  logic          line_start;
  tg_status_t    ev;

  lcd_tg_axis #(.CW(CW)) u_h_axis (
    .clk(clk), .rst_n(rst_n), .adv(1'b1),
    .total(cfg_h_total), .sync_start(cfg_h_sync_start), .sync_end(cfg_h_sync_end),
    .disp_start(cfg_h_disp_start), .active(cfg_h_active),
    .cnt(h_cnt), .pos(h_pos), .sync_on(h_sync_on), .disp_on(h_disp_on), .wrap(h_wrap)
  );

  lcd_tg_axis #(.CW(CW)) u_v_axis (
    .clk(clk), .rst_n(rst_n), .adv(h_wrap),
    .total(cfg_v_total), .sync_start(cfg_v_sync_start), .sync_end(cfg_v_sync_end),
    .disp_start(cfg_v_disp_start), .active(cfg_v_active),
    .cnt(v_cnt), .pos(v_pos), .sync_on(v_sync_on), .disp_on(v_disp_on), .wrap(v_wrap)
  );

  // events are decoded in cycle 0 of a line
  assign line_start      = (h_cnt == '0);
  assign ev[ST_VSYNC]    = line_start && (v_cnt == cfg_v_sync_start);
  assign ev[ST_DISP]     = line_start && (v_cnt == cfg_v_disp_start);
  assign ev[ST_LINE]     = line_start && (v_cnt[CMP_BITS-1:0] == cfg_irq_line);

  lcd_tg_status u_status (
    .clk(clk), .rst_n(rst_n), .events(ev), .clr(status_clr), .status(status)
  );

  assign hsync    = cfg_sync_pol[0] ? h_sync_on : ~h_sync_on;
  assign vsync    = cfg_sync_pol[1] ? v_sync_on : ~v_sync_on;
  assign de       = h_disp_on && v_disp_on;
  assign vblank   = ~v_disp_on;
  assign pix_x    = de ? h_pos : '0;
  assign pix_y    = de ? v_pos : '0;
  assign cur_line = v_cnt;

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |=> (cur_line == '0)); // R2
  AST_DE_VISIBLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (cur_line >= cfg_v_disp_start)); // R4
  AST_VSYNC_AT_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_VSYNC]) |-> ($past(h_cnt) == '0)); // R5
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hss, hse, hds, hact, htot, vss, vse, vds, vact, vtot;
  logic [8:0]  irq;
  logic [1:0]  pol;
  logic [2:0]  clr;
  logic        hsync, vsync, de, vblank;
  logic [15:0] pix_x, pix_y, cur_line;
  logic [2:0]  status;

  int checks = 0;
  int errors = 0;
  int mh, mv;
  logic [2:0] exp_st;
  bit clr_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_sync_start(hss), .cfg_h_sync_end(hse), .cfg_h_disp_start(hds),
    .cfg_h_active(hact), .cfg_h_total(htot),
    .cfg_v_sync_start(vss), .cfg_v_sync_end(vse), .cfg_v_disp_start(vds),
    .cfg_v_active(vact), .cfg_v_total(vtot),
    .cfg_irq_line(irq), .cfg_sync_pol(pol), .status_clr(clr),
    .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank),
    .pix_x(pix_x), .pix_y(pix_y), .cur_line(cur_line), .status(status)
  );

  function automatic bit in_win(input int c, input int lo, input int len_or_end, input bit is_len);
    int hi = is_len ? lo + len_or_end : len_or_end;
    return (c >= lo) && (c < hi);
  endfunction

  function automatic logic level(input bit on, input logic p);
    return on ? p : ~p;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(input string ctag);
    bit hw = in_win(mh, int'(hds), int'(hact), 1'b1);
    bit vw = in_win(mv, int'(vds), int'(vact), 1'b1);
    bit ede = hw && vw;
    chk(ctag, "cur_line", 32'(cur_line), 32'(mv));
    chk("R3", "hsync", 32'(hsync), 32'(level(in_win(mh, int'(hss), int'(hse), 1'b0), pol[0])));
    chk("R3", "vsync", 32'(vsync), 32'(level(in_win(mv, int'(vss), int'(vse), 1'b0), pol[1])));
    chk("R4", "de", 32'(de), 32'(ede));
    chk("R4", "pix_x", 32'(pix_x), ede ? 32'(mh - int'(hds)) : 32'd0);
    chk("R4", "pix_y", 32'(pix_y), ede ? 32'(mv - int'(vds)) : 32'd0);
    chk("R10", "vblank", 32'(vblank), 32'(!vw));
    chk("R5", "status vsync bit", 32'(status[0]), 32'(exp_st[0]));
    chk("R6", "status display bit", 32'(status[1]), 32'(exp_st[1]));
    chk("R7", "status compare bit", 32'(status[2]), 32'(exp_st[2]));
  endtask

  // expected state for the coming clock edge
  task automatic step_model();
    logic [2:0] ev;
    ev[0] = (mh == 0) && (mv == int'(vss));
    ev[1] = (mh == 0) && (mv == int'(vds));
    ev[2] = (mh == 0) && ((mv % 512) == int'(irq));
    exp_st = (exp_st & ~clr) | ev;
    if (mh + 1 >= int'(htot)) begin
      mh = 0;
      mv = (mv + 1 >= int'(vtot)) ? 0 : mv + 1;
    end else begin
      mh = mh + 1;
    end
  endtask

  task automatic drive_clr();
    clr = (clr_en && ($urandom % 4 == 0)) ? 3'($urandom % 8) : 3'b000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 3'b000;
    repeat (2) @(negedge clk);
    chk("R1", "cur_line in reset", 32'(cur_line), 32'd0);
    chk("R1", "status in reset", 32'(status), 32'd0);
    mh = 0; mv = 0; exp_st = 3'b000;
    rst_n = 1'b1;
    drive_clr();
    step_model();
  endtask

  task automatic run(input int n, input string ctag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle(ctag);
      drive_clr();
      step_model();
    end
  endtask

  task automatic rand_cfg(input bit plan_irq);
    hss  = 16'($urandom % 2);
    hse  = hss + 16'(1 + $urandom % 3);
    hds  = hse + 16'(1 + $urandom % 3);
    hact = 16'(2 + $urandom % 6);
    htot = hds + hact + 16'(1 + $urandom % 3);
    vss  = 16'($urandom % 2);
    vse  = vss + 16'(1 + $urandom % 2);
    vds  = vse + 16'(1 + $urandom % 2);
    vact = 16'(2 + $urandom % 4);
    vtot = vds + vact + 16'(1 + $urandom % 2);
    irq  = plan_irq ? 9'(vds + vact) : 9'($urandom % int'(vtot));
    pol  = 2'($urandom % 4);
  endtask

  initial begin
    void'($urandom(32'h5EED_1CD0));
    clr = 3'b000;
    rand_cfg(1'b1);

    // random raster shapes with random clear strobes
    for (int k = 0; k < 8; k++) begin
      rand_cfg(k[0]);
      do_reset();
      run(int'(htot) * int'(vtot) * 3, "R2");
    end

    // R7: frame taller than 512 lines; lines 3 and 515 both match
    hss = 0; hse = 1; hds = 1; hact = 1; htot = 2;
    vss = 0; vse = 1; vds = 2; vact = 500; vtot = 520;
    irq = 9'd3; pol = 2'b11;
    do_reset();
    run(2 * 520 + 8, "R2");

    // R8: no clears for a full frame, all bits stick, then one clear empties them
    rand_cfg(1'b1);
    clr_en = 1'b0;
    do_reset();
    run(int'(htot) * int'(vtot) + 2, "R2");
    chk("R8", "all bits sticky", 32'(status), 32'd7);
    while (mh == 0) run(1, "R2");
    @(negedge clk);
    check_cycle("R2");
    clr = 3'b111;
    step_model();
    @(negedge clk);
    chk("R8", "cleared by write-one", 32'(status), 32'd0);
    check_cycle("R2");
    clr_en = 1'b1;

    // R9: degenerate totals
    hss = 0; hse = 1; hds = 0; hact = 1; htot = 0;
    vss = 0; vse = 1; vds = 0; vact = 1; vtot = 1;
    do_reset();
    run(20, "R9");
    htot = 1; vtot = 4;
    do_reset();
    run(20, "R9");
    htot = 5; vtot = 0;
    do_reset();
    run(20, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule